// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is a serial peripheral interface master that moves a burst of words in one go. A command interface gives the word length (1 to 32 bits), the number of words in the burst (1 to 32), the clock phase, the idle level of the serial clock, the chip select to use, a polarity for each chip select and a half-period divider. A one-cycle go strobe captures these settings and starts the burst.

For each word the engine takes one entry from an outside transmit queue through a pop strobe. It shifts the word out while it shifts a word in, and it hands the received word to an outside receive queue through a push strobe. Transmit and receive can each be disabled. A busy flag covers the whole burst. A ready flag marks completion and stays set until the host clears it by writing 1.

Top module: `spi_burst_master`

## Requirements
- R1: The word-length field `cfg_len_m1` (5 bits) holds bits-per-word minus one. Each word is shifted most significant bit first, starting at bit `cfg_len_m1` of the queue entry. Entry bits above that position are ignored.
- R2: The count field `cfg_cnt_m1` (5 bits) holds words-per-burst minus one. With transmit enabled, `tx_pop` pulses for exactly one cycle per word, so one burst gives `cfg_cnt_m1`+1 pops. Neither `tx_pop` nor `rx_push` is ever high while `busy` is low.
- R3: With `cfg_cpha`=0, `mosi` holds each bit before the leading clock edge, and `miso` is sampled on the leading edge. With `cfg_cpha`=1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge. The leading edge is the first transition away from the idle level.
- R4: When not busy, `sclk` follows `cfg_idle` one cycle later. Codes 0 and 2 give a low level, and codes 1 and 3 give a high level. After a burst, `sclk` rests at the idle level.
- R5: `cfg_cs_sel` (2 bits) selects one of four chip selects. Each output `cs[i]` is asserted at level `cfg_cs_pol[i]` and rests at the opposite level. Only the selected output is asserted. It is asserted from the cycle after go until `busy` falls, and it is still asserted when `ready` rises.
- R6: With `cfg_tx_en`=0, nothing is popped and `mosi` sends all zeros.
- R7: With `cfg_rx_en`=0, nothing is pushed. With `cfg_rx_en`=1, each received word appears on `rx_data` right-aligned, with its upper bits zero, in the cycle of its `rx_push`.
- R8: `ready` rises at the end of the last word while `busy` is still high. A high `rdy_clr` clears it at any time, including while busy. When the set and the clear fall in the same cycle, the set wins.
- R9: A go strobe while `busy` is high is ignored. It adds no words, and no second burst follows.
- R10: Every serial clock half period lasts `cfg_div`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_m1 | input | 5 | Bits per word minus one |
| cfg_cnt_m1 | input | 5 | Words per burst minus one |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_idle | input | 2 | Idle clock level code |
| cfg_cs_sel | input | 2 | Chip select index |
| cfg_cs_pol | input | 4 | Per-chip-select active level |
| cfg_tx_en | input | 1 | Pop and send transmit words |
| cfg_rx_en | input | 1 | Push received words |
| cfg_div | input | 8 | Half-period length minus one, in clk cycles |
| go | input | 1 | Start strobe |
| rdy_clr | input | 1 | Write-1 clear of ready |
| busy | output | 1 | Burst in progress |
| ready | output | 1 | Burst complete, sticky |
| tx_pop | output | 1 | Take one transmit entry this cycle |
| tx_data | input | 32 | Head of the transmit queue |
| rx_push | output | 1 | Store rx_data this cycle |
| rx_data | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip select outputs |

## Verification
The completion event that sets `ready` and the host's write-1 clear can fall in the same clock cycle. To provoke this, the bench holds `rdy_clr` high for a whole burst. The check then requires that `ready` is seen high for exactly one cycle at completion and is low afterwards. A second case pulses the clear during the tail of the burst, while `busy` is still high. There the bench checks that `ready` drops and `busy` stays high, which shows that both flags can be set together and that the clear works independently of `busy`.

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master #(
  parameter int DIV_W = 8,
  parameter int NCS   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             cfg_len_m1,
  input  logic [4:0]             cfg_cnt_m1,
  input  logic                   cfg_cpha,
  input  logic [1:0]             cfg_idle,
  input  logic [$clog2(NCS)-1:0] cfg_cs_sel,
  input  logic [NCS-1:0]         cfg_cs_pol,
  input  logic                   cfg_tx_en,
  input  logic                   cfg_rx_en,
  input  logic [DIV_W-1:0]       cfg_div,
  input  logic                   go,
  input  logic                   rdy_clr,
  output logic                   busy,
  output logic                   ready,
  output logic                   tx_pop,
  input  logic [31:0]            tx_data,
  output logic                   rx_push,
  output logic [31:0]            rx_data,
  output logic                   sclk,
  output logic                   mosi,
  input  logic                   miso,
  output logic [NCS-1:0]         cs
);
  localparam int SEL_W = $clog2(NCS);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_NEXT, S_TAIL} st_t;
  st_t st;

  logic [4:0]       len_q, cnt_q, wcnt;
  logic             cpha_q, txen_q, rxen_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q, hc;
  logic [5:0]       edge_n;
  logic [32:0]      tsr;
  logic [31:0]      rsr;
  logic             sclk_q;

  wire idle_lvl = (cfg_idle == 2'd1) || (cfg_idle == 2'd3);
  wire samp     = (edge_n[0] == cpha_q);
  wire last_wd  = (wcnt == cnt_q);
  wire [5:0] lsh = 6'd32 - {1'b0, len_q} - {5'b0, cpha_q};

  assign busy    = (st != S_IDLE);
  assign tx_pop  = (st == S_LOAD) && txen_q;
  assign rx_push = (st == S_NEXT) && rxen_q;
  assign rx_data = rsr;
  assign sclk    = sclk_q;
  assign mosi    = busy && tsr[32];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs[i] = (busy && sel_q == SEL_W'(i)) ? cfg_cs_pol[i] : ~cfg_cs_pol[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      len_q <= '0; cnt_q <= '0; wcnt <= '0;
      cpha_q <= 1'b0; txen_q <= 1'b0; rxen_q <= 1'b0;
      sel_q <= '0; div_q <= '0; hc <= '0; edge_n <= '0;
      tsr <= '0; rsr <= '0; sclk_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          sclk_q <= idle_lvl;
          if (go) begin
            len_q  <= cfg_len_m1;
            cnt_q  <= cfg_cnt_m1;
            cpha_q <= cfg_cpha;
            txen_q <= cfg_tx_en;
            rxen_q <= cfg_rx_en;
            sel_q  <= cfg_cs_sel;
            div_q  <= cfg_div;
            wcnt   <= '0;
            st     <= S_LOAD;
          end
        end
        S_LOAD: begin
          tsr    <= txen_q ? ({1'b0, tx_data} << lsh) : '0;
          rsr    <= '0;
          edge_n <= '0;
          hc     <= div_q;
          st     <= S_SHIFT;
        end
        S_SHIFT: begin
          if (hc == '0) begin
            hc     <= div_q;
            sclk_q <= ~sclk_q;
            edge_n <= edge_n + 6'd1;
            if (samp) rsr <= {rsr[30:0], miso};
            else      tsr <= {tsr[31:0], 1'b0};
            if (edge_n == {len_q, 1'b1}) st <= S_NEXT;
          end else begin
            hc <= hc - 1'b1;
          end
        end
        S_NEXT: begin
          if (last_wd) begin
            hc <= div_q;
            st <= S_TAIL;
          end else begin
            wcnt <= wcnt + 5'd1;
            st   <= S_LOAD;
          end
        end
        S_TAIL: begin
          if (hc == '0) st <= S_IDLE;
          else          hc <= hc - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ready <= 1'b0;
    else if (st == S_NEXT && last_wd) ready <= 1'b1;
    else if (rdy_clr)               ready <= 1'b0;
  end
endmodule

module spi_burst_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           ready,
  input logic           rdy_clr,
  input logic           tx_pop,
  input logic           rx_push,
  input logic           sclk,
  input logic [1:0]     cfg_idle,
  input logic [NCS-1:0] cs,
  input logic [NCS-1:0] cfg_cs_pol
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_idle_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !busy && $past(!busy) && $stable(cfg_idle)
      |-> sclk == ((cfg_idle == 2'd1) || (cfg_idle == 2'd3)));

  assert_ready_with_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(ready) |-> busy);

  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rdy_clr |=> !ready);

  assert_one_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~(cs ^ cfg_cs_pol)));

  assert_cs_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs == ~cfg_cs_pol);

  assert_no_strobe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_pop && !rx_push);

  assert_single_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);
endmodule

bind spi_burst_master spi_burst_master_chk #(.NCS(NCS)) u_chk (.*);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] cfg_len_m1 = '0, cfg_cnt_m1 = '0;
  logic cfg_cpha = 1'b0, cfg_tx_en = 1'b0, cfg_rx_en = 1'b0;
  logic [1:0] cfg_idle = '0, cfg_cs_sel = '0;
  logic [3:0] cfg_cs_pol = '0;
  logic [7:0] cfg_div = '0;
  logic go = 1'b0, rdy_clr = 1'b0, miso = 1'b0;
  logic busy, ready, tx_pop, rx_push, sclk, mosi;
  logic [31:0] tx_data, rx_data;
  logic [3:0] cs;

  int total = 0, bad = 0, pop_cnt = 0, rx_cnt = 0, cyc = 0;
  logic clr = 1'b0;
  logic [31:0] rxw [32];
  logic [31:0] mos [32];

  always #10 clk = ~clk;

  spi_burst_master u_dut (.*);

  function automatic logic [31:0] txw(int i);
    return 32'hA5C31E00 ^ (32'(i) * 32'h9E3779B1);
  endfunction
  function automatic logic [31:0] sw(int i);
    return 32'h3C5A0F96 + 32'(i) * 32'h01234567;
  endfunction
  function automatic logic [31:0] msk(int n);
    return (n == 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 32'h1);
  endfunction
  function automatic logic sbit(int p, int n, int c);
    int w = p / n;
    logic [31:0] v;
    if (w > c) return 1'b0;
    v = sw(w);
    return v[n - 1 - (p % n)];
  endfunction

  assign tx_data = txw(pop_cnt);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      pop_cnt <= 0; rx_cnt <= 0;
    end else begin
      if (tx_pop) pop_cnt <= pop_cnt + 1;
      if (rx_push) begin
        if (rx_cnt < 32) rxw[rx_cnt] <= rx_data;
        rx_cnt <= rx_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // len, cnt, cpha, idle, sel, pol, tx, rx, div
  localparam int NV = 7;
  localparam logic [28:0] VEC [NV] = '{
    {5'd7,  5'd3,  1'b0, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b1, 8'd1},
    {5'd7,  5'd1,  1'b1, 2'd1, 2'd1, 4'b0010, 1'b1, 1'b1, 8'd0},
    {5'd0,  5'd4,  1'b0, 2'd1, 2'd2, 4'b0100, 1'b1, 1'b1, 8'd2},
    {5'd31, 5'd1,  1'b1, 2'd0, 2'd3, 4'b1111, 1'b1, 1'b1, 8'd0},
    {5'd12, 5'd2,  1'b0, 2'd2, 2'd3, 4'b0000, 1'b0, 1'b1, 8'd1},
    {5'd15, 5'd0,  1'b1, 2'd3, 2'd0, 4'b0001, 1'b1, 1'b0, 8'd3},
    {5'd4,  5'd31, 1'b0, 2'd0, 2'd1, 4'b1010, 1'b1, 1'b1, 8'd0}
  };

  // mode 0 plain, 1 extra go mid-burst, 2 clear held high, 3 clear in tail
  task automatic run(input logic [28:0] v, input int mode);
    int n = int'(v[28:24]) + 1, c = int'(v[23:19]);
    logic cp = v[18], il, prev, lead;
    int sel = int'(v[15:14]), dv = int'(v[7:0]);
    int mq = 0, sp = 0, k = 0, e0 = -1, e1 = -1, rdy_cyc = 0, pops_end;
    bit rdy_seen = 0;
    il = (v[17:16] == 2'd1) || (v[17:16] == 2'd3);
    @(negedge clk);
    cfg_len_m1 = v[28:24]; cfg_cnt_m1 = v[23:19]; cfg_cpha = cp;
    cfg_idle = v[17:16]; cfg_cs_sel = v[15:14]; cfg_cs_pol = v[13:10];
    cfg_tx_en = v[9]; cfg_rx_en = v[8]; cfg_div = v[7:0];
    for (int i = 0; i < 32; i++) mos[i] = '0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    miso = cp ? 1'b0 : sbit(0, n, c);
    prev = sclk;
    go = 1'b1;
    if (mode == 2) rdy_clr = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(busy == 1'b1, "R2 busy after go", busy, 1);
    while (busy && k < 20000) begin
      if (sclk != prev) begin
        if (e0 < 0) e0 = cyc; else if (e1 < 0) e1 = cyc;
        lead = (sclk != il);
        if (cp ? !lead : lead) begin
          if (mq / n < 32) mos[mq / n] = {mos[mq / n][30:0], mosi};
          mq++;
        end
        if (cp ? lead : !lead) begin
          if (cp) begin miso = sbit(sp, n, c); sp++; end
          else begin sp++; miso = sbit(sp, n, c); end
        end
        prev = sclk;
      end
      if (ready) begin
        rdy_cyc++;
        if (!rdy_seen) begin
          rdy_seen = 1;
          chk(busy == 1'b1, "R8 ready while busy", busy, 1);
          chk(cs[sel] == v[10 + sel], "R5 cs held at ready", cs[sel], v[10 + sel]);
          if (mode == 3) begin
            rdy_clr = 1'b1;
            @(negedge clk);
            rdy_clr = 1'b0;
            k++;
            chk(ready == 1'b0 && busy == 1'b1, "R8 clear during busy", {ready, busy}, 2'b01);
          end
        end
      end
      if (mode == 1 && k == 4) go = 1'b1;
      else go = 1'b0;
      @(negedge clk);
      k++;
    end
    go = 1'b0;
    if (k >= 20000) chk(0, "R2 watchdog burst", k, 0);
    rdy_clr = 1'b0;
    chk(rdy_seen, "R8 ready seen", rdy_seen, 1);
    chk(pop_cnt == (v[9] ? c + 1 : 0), "R2 R6 pop count", pop_cnt, v[9] ? c + 1 : 0);
    chk(rx_cnt == (v[8] ? c + 1 : 0), "R7 push count", rx_cnt, v[8] ? c + 1 : 0);
    chk(mq == (c + 1) * n, "R1 bit count", mq, (c + 1) * n);
    for (int w = 0; w <= c; w++) begin
      logic [31:0] et = v[9] ? (txw(w) & msk(n)) : 32'h0;
      chk(mos[w] == et, "R1 R3 R6 mosi word", mos[w], et);
      if (v[8]) chk(rxw[w] == (sw(w) & msk(n)), "R3 R7 rx word", rxw[w], sw(w) & msk(n));
    end
    chk(e1 - e0 == dv + 1, "R10 half period", e1 - e0, dv + 1);
    chk(cs == ~v[13:10], "R5 cs released", cs, ~v[13:10]);
    @(negedge clk);
    chk(sclk == il, "R4 idle after burst", sclk, il);
    if (mode == 2) chk(rdy_cyc == 1 && ready == 1'b0, "R8 set wins then clears", rdy_cyc, 1);
    else if (mode != 3) chk(ready == 1'b1, "R8 ready sticky", ready, 1);
    if (mode == 1) begin
      pops_end = pop_cnt;
      repeat (6) @(negedge clk);
      chk(busy == 1'b0 && pop_cnt == pops_end, "R9 go ignored", {busy, 32'(pop_cnt)}, {1'b0, 32'(pops_end)});
    end
    rdy_clr = 1'b1;
    @(negedge clk);
    rdy_clr = 1'b0;
    chk(ready == 1'b0, "R8 clear idle", ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_cs_pol = 4'b0101;
    repeat (3) @(negedge clk);
    chk(busy == 0 && ready == 0, "R8 reset flags", {busy, ready}, 0);
    chk(cs == 4'b1010, "R5 reset cs", cs, 4'b1010);
    chk(tx_pop == 0 && rx_push == 0, "R2 reset strobes", {tx_pop, rx_push}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_idle = 2'd3;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R4 idle code 3", sclk, 1);
    cfg_idle = 2'd2;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R4 idle code 2", sclk, 0);

    for (int i = 0; i < NV; i++) run(VEC[i], 0);

    run({5'd9, 5'd2, 1'b0, 2'd0, 2'd1, 4'b0000, 1'b1, 1'b1, 8'd1}, 1);
    run({5'd5, 5'd1, 1'b1, 2'd1, 2'd2, 4'b0100, 1'b1, 1'b1, 8'd0}, 2);
    run({5'd3, 5'd0, 1'b0, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b1, 8'd6}, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule